// File: doc/BRIEF.md
# Reset and Wake-up Sequencer

This block decides how a small microcontroller core comes out of reset and out of its low-power HALT state. It watches four causes: a power-on detect level, an active-low external reset pin, a one-cycle watchdog time-out strobe, and a wake-up event. Each cause is sorted into one of three kinds:

- **Cold reset:** clears the program counter, the stack pointer and every peripheral.
- **Warm reset:** a watchdog time-out while the core is halted. It clears only the program counter and the stack pointer.
- **Plain HALT wake-up:** resets nothing.

For every kind, the core is stalled while a start-up timer counts 2^SST_BITS oscillator clocks. The timer is a counter that releases the core when it wraps. A cold reset adds a further option-load wait of OPT_DLY clocks before release.

Two status flags let software tell the causes apart after release: a time-out flag and a power-down flag. The external pin goes through a two-stage synchroniser. The block holds reset for as long as the pin stays low, and starts the start-up count only once the pin is high again. If a new reset cause arrives while the block is still counting, the count starts over. All pins are plain control and status levels; there is no streaming interface, so no handshake applies.

Top module: `rst_wake_seq`

## Requirements
- R1: A watchdog strobe taken while running with `halt_i`=1 is a warm reset: `rst_pcsp_o`=1 and `rst_periph_o`=0 for the whole stall, flags become TO=1/PDF=1, and the stall lasts exactly 2^SST_BITS cycles.
- R2: Flag updates by cause: watchdog strobe with `halt_i`=0 sets TO=1 and keeps PDF; external pin low with `halt_i`=0 keeps both flags; external pin low with `halt_i`=1 gives TO=0/PDF=1.
- R3: While `por_i` is high, all state is reset at once: `core_run_o`=0, both reset outputs are 1, and both flags are 0.
- R4: Every reset and every HALT wake-up holds `core_run_o` low for a start-up count of exactly 2^SST_BITS cycles, after any pin hold.
- R5: Cold resets (power-on, external pin, watchdog with `halt_i`=0) add OPT_DLY further stall cycles after the start-up count. Warm resets and wake-ups add none.
- R6: A low on `ext_rst_n_i` for L sampled cycles stalls the core for L + 2^SST_BITS + OPT_DLY cycles. The stall starts two cycles after the pin is first sampled low (synchroniser latency).
- R7: `wake_i` while running with `halt_i`=1 stalls the core for 2^SST_BITS cycles with both reset outputs low and the flags unchanged. `wake_i` with `halt_i`=0 has no effect.
- R8: When the synchronised pin low and a watchdog strobe reach the sequencer in the same cycle, the pin wins, and only the pin's flag update is applied. Power-on overrides both.
- R9: A watchdog strobe or pin low arriving during the start-up count or the option-load wait restarts the sequence from a zero count.
- R10: `rst_periph_o`=1 implies `rst_pcsp_o`=1, and either reset output being high implies `core_run_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| por_i | input | 1 | Power-on detect, active high, asynchronous reset of the block |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous to `clk_i` |
| wdt_to_i | input | 1 | Watchdog time-out strobe, one cycle |
| halt_i | input | 1 | Core is in HALT |
| wake_i | input | 1 | Wake-up event from HALT |
| core_run_o | output | 1 | Core released (1) or stalled (0) |
| rst_pcsp_o | output | 1 | Reset for the program counter and stack pointer |
| rst_periph_o | output | 1 | Reset for the interrupt enable, prescaler, watchdog, timer, ports and other state |
| flag_to_o | output | 1 | Time-out status flag |
| flag_pdf_o | output | 1 | Power-down status flag |

## Verification
The in-design assertions check the following on every cycle:
- the warm-reset scope of reset outputs and flags;
- the watchdog-in-run flag update;
- the hold while the synchronised pin is low;
- the quiet HALT wake-up;
- the zero-count restart of the sequence;
- that the core is released only on a finished count;
- the ordering between the reset outputs and release.

The exact stall lengths (2^SST_BITS, the option-load add-on, and the pin-hold plus synchroniser arithmetic), the priority between coincident causes, and the flag values seen after release come only from the bench's scenarios. The bench sweeps these with a small start-up counter.

// File: rtl/rws_pkg.sv
package rws_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HOLD = 2'd1,
    ST_SST  = 2'd2,
    ST_OPT  = 2'd3
  } seq_st_e;

  typedef enum logic [1:0] {
    K_COLD = 2'd0,
    K_WARM = 2'd1,
    K_WAKE = 2'd2
  } rst_kind_e;

  typedef struct packed {
    logic to;
    logic pdf;
  } stat_t;
endpackage

// File: rtl/rws_sync2.sv
module rws_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic arst_i,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or posedge arst_i) begin
    if (arst_i) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/rws_cnt.sv
module rws_cnt #(
  parameter int            W    = 4,
  parameter logic [W-1:0]  LAST = '1
) (
  input  logic clk_i,
  input  logic arst_i,
  input  logic clr_i,
  input  logic en_i,
  output logic done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or posedge arst_i) begin
    if (arst_i)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = en_i && (cnt_q == LAST);

  // R9: a clear always restarts the count from zero
  p_clr_zero_r9: assert property (@(posedge clk_i) disable iff (arst_i)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/rws_classify.sv
module rws_classify
  import rws_pkg::*;
(
  input  seq_st_e   st_i,
  input  logic      pin_low_i,
  input  logic      wdt_i,
  input  logic      wake_i,
  input  logic      halt_i,
  input  stat_t     flags_q_i,
  output logic      take_o,
  output logic      hold_o,
  output rst_kind_e kind_o,
  output stat_t     flags_d_o
);
  logic accept;

  always_comb begin
    accept    = (st_i != ST_HOLD);
    take_o    = 1'b0;
    hold_o    = 1'b0;
    kind_o    = K_COLD;
    flags_d_o = flags_q_i;
    if (accept && pin_low_i) begin
      take_o = 1'b1;
      hold_o = 1'b1;
      kind_o = K_COLD;
      if (halt_i) flags_d_o = '{to: 1'b0, pdf: 1'b1};
    end else if (accept && wdt_i) begin
      take_o = 1'b1;
      if (halt_i) begin
        kind_o    = K_WARM;
        flags_d_o = '{to: 1'b1, pdf: 1'b1};
      end else begin
        kind_o       = K_COLD;
        flags_d_o.to = 1'b1;
      end
    end else if ((st_i == ST_RUN) && wake_i && halt_i) begin
      take_o = 1'b1;
      kind_o = K_WAKE;
    end
  end
endmodule

// File: rtl/rst_wake_seq.sv
module rst_wake_seq
  import rws_pkg::*;
#(
  parameter int SST_BITS = 10,
  parameter int OPT_DLY  = 16
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic ext_rst_n_i,
  input  logic wdt_to_i,
  input  logic halt_i,
  input  logic wake_i,
  output logic core_run_o,
  output logic rst_pcsp_o,
  output logic rst_periph_o,
  output logic flag_to_o,
  output logic flag_pdf_o
);
  localparam int OPT_W = (OPT_DLY > 1) ? $clog2(OPT_DLY) : 1;
  localparam logic [SST_BITS-1:0] SST_LAST = '1;
  localparam logic [OPT_W-1:0]    OPT_LAST = OPT_W'(OPT_DLY - 1);

  seq_st_e   st_q;
  rst_kind_e kind_q, ev_kind;
  stat_t     flags_q, flags_d;
  logic      pin_sync, pin_low;
  logic      ev_take, ev_hold;
  logic      sst_done, opt_done;

  rws_sync2 #(.RST_VAL(1'b1)) pin_sync_i (
    .clk_i  (clk_i),
    .arst_i (por_i),
    .d_i    (ext_rst_n_i),
    .q_o    (pin_sync)
  );
  assign pin_low = !pin_sync;

  rws_classify cls_i (
    .st_i      (st_q),
    .pin_low_i (pin_low),
    .wdt_i     (wdt_to_i),
    .wake_i    (wake_i),
    .halt_i    (halt_i),
    .flags_q_i (flags_q),
    .take_o    (ev_take),
    .hold_o    (ev_hold),
    .kind_o    (ev_kind),
    .flags_d_o (flags_d)
  );

  rws_cnt #(.W(SST_BITS), .LAST(SST_LAST)) sst_cnt_i (
    .clk_i  (clk_i),
    .arst_i (por_i),
    .clr_i  (ev_take || (st_q != ST_SST)),
    .en_i   ((st_q == ST_SST) && !ev_take),
    .done_o (sst_done)
  );

  rws_cnt #(.W(OPT_W), .LAST(OPT_LAST)) opt_cnt_i (
    .clk_i  (clk_i),
    .arst_i (por_i),
    .clr_i  (ev_take || (st_q != ST_OPT)),
    .en_i   ((st_q == ST_OPT) && !ev_take),
    .done_o (opt_done)
  );

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      st_q    <= ST_HOLD;
      kind_q  <= K_COLD;
      flags_q <= '{to: 1'b0, pdf: 1'b0};
    end else if (ev_take) begin
      flags_q <= flags_d;
      kind_q  <= ev_kind;
      st_q    <= ev_hold ? ST_HOLD : ST_SST;
    end else begin
      unique case (st_q)
        ST_HOLD: if (!pin_low) st_q <= ST_SST;
        ST_SST:  if (sst_done) st_q <= (kind_q == K_COLD) ? ST_OPT : ST_RUN;
        ST_OPT:  if (opt_done) st_q <= ST_RUN;
        default: st_q <= st_q;
      endcase
    end
  end

  assign core_run_o   = (st_q == ST_RUN);
  assign rst_pcsp_o   = (st_q != ST_RUN) && (kind_q != K_WAKE);
  assign rst_periph_o = (st_q != ST_RUN) && (kind_q == K_COLD);
  assign flag_to_o    = flags_q.to;
  assign flag_pdf_o   = flags_q.pdf;

  // R1: watchdog while halted touches only PC/SP and sets both flags
  p_warm_scope_r1: assert property (@(posedge clk_i) disable iff (por_i)
    (core_run_o && !pin_low && wdt_to_i && halt_i)
      |=> (rst_pcsp_o && !rst_periph_o && flag_to_o && flag_pdf_o));

  // R2: watchdog in run sets TO, keeps PDF, full reset
  p_wdt_run_flags_r2: assert property (@(posedge clk_i) disable iff (por_i)
    (core_run_o && !pin_low && wdt_to_i && !halt_i)
      |=> (flag_to_o && (flag_pdf_o == $past(flag_pdf_o)) && rst_periph_o));

  // R4: release only on a finished count
  p_release_on_done_r4: assert property (@(posedge clk_i) disable iff (por_i)
    $rose(core_run_o) |-> $past(sst_done || opt_done));

  // R6: synchronised pin low keeps the core stalled
  p_pin_hold_r6: assert property (@(posedge clk_i) disable iff (por_i)
    pin_low |=> !core_run_o);

  // R7: plain wake-up resets nothing and leaves flags
  p_wake_quiet_r7: assert property (@(posedge clk_i) disable iff (por_i)
    (core_run_o && wake_i && halt_i && !pin_low && !wdt_to_i)
      |=> (!core_run_o && !rst_pcsp_o && $stable({flag_to_o, flag_pdf_o})));

  // R9: new cause during counting restarts the start-up count
  p_restart_r9: assert property (@(posedge clk_i) disable iff (por_i)
    (((st_q == ST_SST) || (st_q == ST_OPT)) && !pin_low && wdt_to_i)
      |=> (st_q == ST_SST));

  // R10: reset ordering
  p_rst_order_r10: assert property (@(posedge clk_i) disable iff (por_i)
    (rst_periph_o |-> rst_pcsp_o) and ((rst_pcsp_o || rst_periph_o) |-> !core_run_o));
endmodule

// File: tb/rst_wake_seq_tb_top.sv
`timescale 1ns/1ps
module rst_wake_seq_tb_top;
  localparam int SSTB = 4;
  localparam int OPTD = 3;
  localparam int SSTN = 1 << SSTB;

  logic clk = 1'b0;
  logic por, ext_n, wdt, halt, wake;
  logic run, rpcsp, rperiph, fto, fpdf;

  int n_chk = 0, n_bad = 0;
  int lowcnt = 0, cyc = 0, viol = 0;
  bit saw_pcsp = 0, saw_periph = 0;

  always #2.5 clk = ~clk;

  rst_wake_seq #(.SST_BITS(SSTB), .OPT_DLY(OPTD)) dut_i (
    .clk_i(clk), .por_i(por), .ext_rst_n_i(ext_n), .wdt_to_i(wdt),
    .halt_i(halt), .wake_i(wake), .core_run_o(run), .rst_pcsp_o(rpcsp),
    .rst_periph_o(rperiph), .flag_to_o(fto), .flag_pdf_o(fpdf)
  );

  always @(posedge clk) begin
    #1;
    cyc++;
    if (!run) lowcnt++;
    if (rpcsp) saw_pcsp = 1;
    if (rperiph) saw_periph = 1;
    if ((rperiph && !rpcsp) || ((rperiph || rpcsp) && run)) viol++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic open_win();
    lowcnt = 0; saw_pcsp = 0; saw_periph = 0;
  endtask

  task automatic wait_run();
    repeat (2) @(negedge clk);
    while (!run) @(negedge clk);
  endtask

  task automatic wdt_pulse(input logic h);
    halt = h; wdt = 1'b1;
    @(negedge clk);
    wdt = 1'b0;
  endtask

  task automatic pin_pulse(input int len);
    ext_n = 1'b0;
    repeat (len) @(negedge clk);
    ext_n = 1'b1;
  endtask

  task automatic flags(string tag, int to_e, int pdf_e);
    chk({tag, " TO"}, int'(fto), to_e);
    chk({tag, " PDF"}, int'(fpdf), pdf_e);
  endtask

  initial begin
    por = 1'b1; ext_n = 1'b1; wdt = 1'b0; halt = 1'b0; wake = 1'b0;
    repeat (4) @(negedge clk);
    // R3 reset state
    chk("R3 core_run in reset", int'(run), 0);
    chk("R3 rst_pcsp in reset", int'(rpcsp), 1);
    chk("R3 rst_periph in reset", int'(rperiph), 1);
    flags("R3 reset", 0, 0);
    open_win(); por = 1'b0;
    wait_run();
    chk("R3 R4 R5 power-up stall", lowcnt, SSTN + OPTD);
    chk("R3 periph reset seen", int'(saw_periph), 1);
    flags("R3 after release", 0, 0);

    // R2 R5 watchdog in run
    open_win(); wdt_pulse(1'b0); wait_run();
    chk("R5 wdt cold stall", lowcnt, SSTN + OPTD);
    chk("R2 wdt cold periph", int'(saw_periph), 1);
    flags("R2 wdt run", 1, 0);

    // R1 R4 warm reset
    open_win(); wdt_pulse(1'b1); wait_run(); halt = 1'b0;
    chk("R1 R4 warm stall", lowcnt, SSTN);
    chk("R1 warm pcsp", int'(saw_pcsp), 1);
    chk("R1 warm no periph", int'(saw_periph), 0);
    flags("R1 warm", 1, 1);

    // R6 R2 pin length sweep in run
    for (int len = 1; len <= 8; len++) begin
      open_win(); pin_pulse(len); wait_run();
      chk("R6 pin stall", lowcnt, len + SSTN + OPTD);
      chk("R6 pin periph", int'(saw_periph), 1);
      flags("R2 pin run keeps", 1, 1);
    end

    // R2 pin while halted
    halt = 1'b1;
    open_win(); pin_pulse(3); wait_run(); halt = 1'b0;
    chk("R2 pin halt stall", lowcnt, 3 + SSTN + OPTD);
    flags("R2 pin halt", 0, 1);

    // R7 plain wake
    halt = 1'b1; open_win(); wake = 1'b1;
    @(negedge clk); wake = 1'b0;
    wait_run(); halt = 1'b0;
    chk("R7 wake stall", lowcnt, SSTN);
    chk("R7 wake no pcsp", int'(saw_pcsp), 0);
    chk("R7 wake no periph", int'(saw_periph), 0);
    flags("R7 wake keeps", 0, 1);
    open_win(); wake = 1'b1;
    repeat (5) @(negedge clk); wake = 1'b0;
    repeat (5) @(negedge clk);
    chk("R7 wake ignored when not halted", lowcnt, 0);

    // R3 power-on in mid run
    por = 1'b1; @(negedge clk);
    flags("R3 por mid run", 0, 0);
    chk("R3 por mid run stall", int'(run), 0);
    repeat (2) @(negedge clk);
    open_win(); por = 1'b0; wait_run();
    chk("R3 por mid run length", lowcnt, SSTN + OPTD);
    open_win(); wdt_pulse(1'b0); wait_run();
    flags("R2 prep", 1, 0);

    // R8 coincident pin and watchdog, halted
    halt = 1'b1; open_win();
    ext_n = 1'b0;
    @(negedge clk); @(negedge clk);
    wdt = 1'b1; @(negedge clk); wdt = 1'b0;
    @(negedge clk); ext_n = 1'b1;
    wait_run(); halt = 1'b0;
    flags("R8 pin wins", 0, 1);
    chk("R8 periph reset", int'(saw_periph), 1);
    chk("R8 stall", lowcnt, 4 + SSTN + OPTD);

    // R9 restart during start-up count and during option wait
    open_win(); wdt_pulse(1'b0);
    repeat (9) @(negedge clk);
    wdt_pulse(1'b0); wait_run();
    chk("R9 restart in count", lowcnt, 10 + SSTN + OPTD);
    open_win(); wdt_pulse(1'b0);
    repeat (16) @(negedge clk);
    wdt_pulse(1'b0); wait_run();
    chk("R9 restart in option wait", lowcnt, SSTN + 1 + SSTN + OPTD);

    chk("R10 reset ordering violations", viol, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule